// File: doc/BRIEF.md
# Serial BCH(15,7) Error-Trapping Decoder

This block decodes one word of the binary BCH(15,7) code, which has a minimum distance of 5. It corrects any pattern of up to two bit errors. The 15-bit received word arrives on a single serial line, one bit per clock, starting with the most significant bit. While the bits arrive, a divider register reduces the word modulo the generator polynomial g(x) = x^8 + x^7 + x^6 + x^4 + 1. This leaves the 8-bit syndrome.

After the last bit, the decoder searches for a shift j at which the weight of x^j·s(x) mod g(x) is two or less. At that point the errors sit inside the parity window of the cyclically shifted word. The trapped syndrome is then rotated back by j positions to form the 15-bit error pattern. That pattern is XORed onto the whole received word, so errors in the parity bits are fixed as well as errors in the message bits. The code is systematic, and the seven message bits occupy codeword bits 14..8.

Several shift values are tested in each clock. The full cyclic range of 15 shifts therefore takes a fixed, small number of clocks. A host drives an enable line for the whole decode, watches a busy flag, and reads the message together with a success or failure flag.

Top module: `bch15_decoder`

## Requirements
- R1: While `run_en` is high and the block is not finished, `serial_in` is sampled on each rising edge. The first sample is taken on the edge where `run_en` is first seen high. The first of the 15 samples is codeword bit 14, the most significant bit.
- R2: A valid codeword with no errors is reported one clock after the edge that samples its last bit. At that point `done_ok` is 1, `fail` is 0, and `msg_out` equals codeword bits 14..8. Codewords are systematic under g(x) = x^8 + x^7 + x^6 + x^4 + 1.
- R3: If the received word lies within Hamming distance 2 of a codeword, `msg_out` returns that codeword's bits 14..8 with `done_ok` = 1. This holds whether the errors hit message bits or parity bits, and it includes words with more than two errors that land near another codeword.
- R4: Take the smallest left cyclic shift j (0..14) that moves every error position into bits 7..0. A correctable word is reported exactly floor(j/4)+1 clocks after its last bit, so never later than 4 clocks.
- R5: A word with no codeword within distance 2 sets `fail` = 1 and leaves `done_ok` = 0. This happens 4 clocks after the last bit, and `msg_out` then holds the uncorrected received bits 14..8.
- R6: `busy` is high whenever `run_en` is high and the decode has not finished. It is low once `done_ok` or `fail` is set. It never stays high for more than 19 consecutive clocks.
- R7: Dropping `run_en` forces `busy` low in the same cycle and abandons any decode in progress. The next decode starts from an empty syndrome.
- R8: After completion, with `run_en` still high, `done_ok`, `fail` and `msg_out` hold their values and `serial_in` is ignored. On the first edge with `run_en` low, `done_ok` and `fail` clear.
- R9: While `rst_n` is low, `busy`, `done_ok` and `fail` are 0 and `msg_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Held high by the host for the duration of one decode |
| serial_in | input | 1 | Received word, one bit per clock, MSB first |
| busy | output | 1 | Decode in progress |
| done_ok | output | 1 | Decode finished with a (possibly corrected) message |
| fail | output | 1 | Decode finished, word not correctable |
| msg_out | output | 7 | Decoded message bits |

## Verification
The checks assume a well-behaved host. It raises `run_en` only while the block is idle and keeps it high across all 15 bits, unless it means to abort. It lowers `run_en` only after a result, or on purpose to abandon a decode. Under those conditions the busy window is bounded and the completion flags stay mutually exclusive and steady.

The stimulus keeps to this host behaviour. Every decode is a 15-bit burst with `run_en` held high, followed by a deliberate release once a result appears. One directed case aborts mid-word. Random words carry zero to four errors, and the expected message and latency come from a brute-force nearest-codeword search.

// File: rtl/bch15_pkg.sv
package bch15_pkg;

  localparam int unsigned CW_LEN  = 15;
  localparam int unsigned MSG_LEN = 7;
  localparam int unsigned PAR_LEN = CW_LEN - MSG_LEN;
  localparam int unsigned T_CORR  = 2;

  // g(x) = x^8 + x^7 + x^6 + x^4 + 1 without its leading term
  localparam logic [PAR_LEN-1:0] GEN_TAIL = 8'hD1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_SRCH,
    ST_DONE
  } dec_state_e;

  // multiply a residue by x and reduce modulo g(x)
  function automatic logic [PAR_LEN-1:0] mulx_mod(input logic [PAR_LEN-1:0] s);
    return {s[PAR_LEN-2:0], 1'b0} ^ (s[PAR_LEN-1] ? GEN_TAIL : '0);
  endfunction

  function automatic bit low_weight(input logic [PAR_LEN-1:0] s);
    return $countones(s) <= int'(T_CORR);
  endfunction

endpackage

// File: rtl/bch15_frontend.sv
module bch15_frontend
  import bch15_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                shift_en,
  input  logic                din,
  input  logic                load_en,
  input  logic [PAR_LEN-1:0]  load_val,
  output logic [PAR_LEN-1:0]  syn_q,
  output logic [CW_LEN-1:0]   rx_q
);

  logic [PAR_LEN-1:0] syn_d;
  logic [CW_LEN-1:0]  rx_d;

  // Horner division: each new bit enters as the lowest coefficient
  always_comb begin
    syn_d = syn_q;
    rx_d  = rx_q;
    if (clr) begin
      syn_d = '0;
      rx_d  = '0;
    end else if (shift_en) begin
      syn_d = mulx_mod(syn_q) ^ {{(PAR_LEN-1){1'b0}}, din};
      rx_d  = {rx_q[CW_LEN-2:0], din};
    end else if (load_en) begin
      syn_d = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syn_q <= '0;
      rx_q  <= '0;
    end else begin
      syn_q <= syn_d;
      rx_q  <= rx_d;
    end
  end

endmodule

// File: rtl/bch15_trap_search.sv
module bch15_trap_search
  import bch15_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned LW   = (LANES > 1) ? $clog2(LANES) : 1
)(
  input  logic [PAR_LEN-1:0] syn,
  output logic               hit,
  output logic [LW-1:0]      hit_lane,
  output logic [PAR_LEN-1:0] trapped,
  output logic [PAR_LEN-1:0] syn_adv
);

  logic [PAR_LEN-1:0] lane_syn [0:LANES];
  logic [LANES-1:0]   lane_ok;

  assign lane_syn[0] = syn;

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    assign lane_syn[g+1] = mulx_mod(lane_syn[g]);
    assign lane_ok[g]    = low_weight(lane_syn[g]);
  end

  assign syn_adv = lane_syn[LANES];

  // lowest shift wins
  always_comb begin
    hit      = 1'b0;
    hit_lane = '0;
    trapped  = '0;
    for (int l = int'(LANES) - 1; l >= 0; l--) begin
      if (lane_ok[l]) begin
        hit      = 1'b1;
        hit_lane = LW'(l);
        trapped  = lane_syn[l];
      end
    end
  end

endmodule

// File: rtl/bch15_corrector.sv
module bch15_corrector
  import bch15_pkg::*;
#(
  parameter int unsigned JW = 4
)(
  input  logic [CW_LEN-1:0]  rx,
  input  logic [PAR_LEN-1:0] trapped,
  input  logic [JW-1:0]      shift,
  output logic [MSG_LEN-1:0] msg
);

  logic [CW_LEN-1:0] pat;
  logic [CW_LEN-1:0] err_vec;
  logic [CW_LEN-1:0] fixed;

  assign pat = {{MSG_LEN{1'b0}}, trapped};

  // e(x) = x^(15-j) * s_j(x) mod (x^15 + 1): a right rotation by j
  always_comb begin
    for (int i = 0; i < int'(CW_LEN); i++) begin
      int idx;
      idx = i + int'(shift);
      if (idx >= int'(CW_LEN)) idx = idx - int'(CW_LEN);
      err_vec[i] = pat[idx];
    end
  end

  assign fixed = rx ^ err_vec;
  assign msg   = fixed[CW_LEN-1:PAR_LEN];

endmodule

// File: rtl/bch15_decoder.sv
module bch15_decoder
  import bch15_pkg::*;
#(
  parameter int unsigned LANES = 4
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               serial_in,
  output logic               busy,
  output logic               done_ok,
  output logic               fail,
  output logic [MSG_LEN-1:0] msg_out
);

  localparam int unsigned GROUPS = (CW_LEN + LANES - 1) / LANES;
  localparam int unsigned GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int unsigned LW     = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int unsigned JW     = $clog2(GROUPS * LANES);
  localparam int unsigned CNT_W  = $clog2(CW_LEN);

  dec_state_e          state_q, state_d;
  logic [CNT_W-1:0]    bitcnt_q, bitcnt_d;
  logic [GRP_W-1:0]    grp_q, grp_d;
  logic                ok_q, ok_d;
  logic                fail_q, fail_d;
  logic [MSG_LEN-1:0]  word_q, word_d;

  logic                shift_en, load_en;
  logic [PAR_LEN-1:0]  syn_q, syn_adv, trapped;
  logic [CW_LEN-1:0]   rx_q;
  logic                hit;
  logic [LW-1:0]       hit_lane;
  logic [JW-1:0]       j_sel;
  logic [MSG_LEN-1:0]  fixed_msg;

  bch15_frontend u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!run_en),
    .shift_en (shift_en),
    .din      (serial_in),
    .load_en  (load_en),
    .load_val (syn_adv),
    .syn_q    (syn_q),
    .rx_q     (rx_q)
  );

  bch15_trap_search #(.LANES(LANES)) u_search (
    .syn      (syn_q),
    .hit      (hit),
    .hit_lane (hit_lane),
    .trapped  (trapped),
    .syn_adv  (syn_adv)
  );

  assign j_sel = JW'(grp_q) * JW'(LANES) + JW'(hit_lane);

  bch15_corrector #(.JW(JW)) u_fix (
    .rx      (rx_q),
    .trapped (trapped),
    .shift   (j_sel),
    .msg     (fixed_msg)
  );

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    grp_d    = grp_q;
    ok_d     = ok_q;
    fail_d   = fail_q;
    word_d   = word_q;
    shift_en = 1'b0;
    load_en  = 1'b0;
    if (!run_en) begin
      state_d  = ST_IDLE;
      bitcnt_d = '0;
      grp_d    = '0;
      ok_d     = 1'b0;
      fail_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          shift_en = 1'b1;
          bitcnt_d = CNT_W'(1);
          state_d  = ST_RECV;
        end
        ST_RECV: begin
          shift_en = 1'b1;
          bitcnt_d = bitcnt_q + CNT_W'(1);
          grp_d    = '0;
          if (bitcnt_q == CNT_W'(CW_LEN - 1)) state_d = ST_SRCH;
        end
        ST_SRCH: begin
          if (hit) begin
            ok_d    = 1'b1;
            word_d  = fixed_msg;
            state_d = ST_DONE;
          end else if (grp_q == GRP_W'(GROUPS - 1)) begin
            fail_d  = 1'b1;
            word_d  = rx_q[CW_LEN-1:PAR_LEN];
            state_d = ST_DONE;
          end else begin
            load_en = 1'b1;
            grp_d   = grp_q + GRP_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      grp_q    <= '0;
      ok_q     <= 1'b0;
      fail_q   <= 1'b0;
      word_q   <= '0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      grp_q    <= grp_d;
      ok_q     <= ok_d;
      fail_q   <= fail_d;
      word_q   <= word_d;
    end
  end

  assign busy    = run_en && (state_q != ST_DONE);
  assign done_ok = ok_q;
  assign fail    = fail_q;
  assign msg_out = word_q;

endmodule

// File: rtl/bch15_decoder_chk.sv
module bch15_decoder_chk #(
  parameter int unsigned LANES = 4
)(
  input logic       clk,
  input logic       rst_n,
  input logic       run_en,
  input logic       busy,
  input logic       done_ok,
  input logic       fail,
  input logic [6:0] msg_out
);

  localparam int unsigned MAX_BUSY = 15 + (15 + LANES - 1) / LANES;

  logic [5:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_q <= '0;
    else if (!busy)       run_q <= '0;
    else if (run_q != '1) run_q <= run_q + 6'd1;
  end

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 6'(MAX_BUSY));

  // R6
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || fail) |-> !busy);

  // R7
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !busy);

  // R8
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!done_ok && !fail));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok && $past(done_ok)) |-> $stable(msg_out));

  // R5
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && fail));

  // R2
  rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_ok) |-> $past(run_en));

endmodule

bind bch15_decoder bch15_decoder_chk #(.LANES(LANES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run_en  (run_en),
  .busy    (busy),
  .done_ok (done_ok),
  .fail    (fail),
  .msg_out (msg_out)
);

// File: tb/sim_bch15_decoder.sv
module sim_bch15_decoder;

  localparam int LANES = 4;
  localparam int GROUPS = 4;

  logic clk, rst_n, run_en, serial_in;
  logic busy, done_ok, fail;
  logic [6:0] msg_out;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  bch15_decoder u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .serial_in(serial_in),
    .busy(busy), .done_ok(done_ok), .fail(fail), .msg_out(msg_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [14:0] enc(input logic [6:0] m);
    logic [14:0] r;
    r = {m, 8'b0};
    for (int i = 14; i >= 8; i--)
      if (r[i]) r = r ^ (15'h1D1 << (i - 8));
    return {m, r[7:0]};
  endfunction

  function automatic logic [14:0] rotl(input logic [14:0] v, input int j);
    logic [14:0] o;
    for (int p = 0; p < 15; p++) o[(p + j) % 15] = v[p];
    return o;
  endfunction

  task automatic run_case(input logic [14:0] rx, input string tag);
    bit found = 0;
    logic [6:0] exp_msg = rx[14:8];
    int exp_lat = GROUPS;
    int got = 0;
    logic [6:0] held;
    for (int m = 0; m < 128; m++) begin
      if (!found && $countones(enc(7'(m)) ^ rx) <= 2) begin
        found = 1;
        exp_msg = 7'(m);
      end
    end
    if (found) begin
      logic [14:0] e = rx ^ enc(exp_msg);
      for (int j = 14; j >= 0; j--)
        if (rotl(e, j)[14:8] == 7'b0) exp_lat = j / LANES + 1;
    end
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      run_en = 1'b1;
      serial_in = rx[14 - i];
      #1;
      if (i == 0) chk(busy == 1'b1, "R6 busy at start", int'(busy), 1);
    end
    @(posedge clk);
    for (int c = 1; c <= 8; c++) begin
      @(posedge clk);
      @(negedge clk);
      serial_in = 1'($urandom_range(0, 1));
      if (got == 0 && (done_ok || fail)) got = c;
      if (got != 0) break;
    end
    if (found) begin
      chk(done_ok == 1'b1 && fail == 1'b0, {tag, " R3 flags"}, int'({done_ok, fail}), 2);
      chk(msg_out == exp_msg, {tag, " R3 message"}, int'(msg_out), int'(exp_msg));
      chk(got == exp_lat, {tag, " R4 latency"}, got, exp_lat);
    end else begin
      chk(fail == 1'b1 && done_ok == 1'b0, {tag, " R5 flags"}, int'({done_ok, fail}), 1);
      chk(msg_out == rx[14:8], {tag, " R5 raw message"}, int'(msg_out), int'(rx[14:8]));
      chk(got == GROUPS, {tag, " R5 latency"}, got, GROUPS);
    end
    chk(busy == 1'b0, {tag, " R6 busy after result"}, int'(busy), 0);
    held = msg_out;
    repeat (2) begin
      @(negedge clk);
      serial_in = ~serial_in;
    end
    chk(msg_out == held && (done_ok || fail), {tag, " R8 hold"}, int'(msg_out), int'(held));
    run_en = 1'b0;
    #1;
    chk(busy == 1'b0, {tag, " R7 busy drop"}, int'(busy), 0);
    @(negedge clk);
    chk(!done_ok && !fail, {tag, " R8 clear"}, int'({done_ok, fail}), 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd4242);
    rst_n = 1'b0;
    run_en = 1'b0;
    serial_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done_ok && !fail && msg_out == 7'd0, "R9 reset state",
        int'({busy, done_ok, fail, msg_out}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_case(enc(7'b1000000), "R1 bit order");
    run_case(enc(7'h00), "R2 zero word");
    run_case(enc(7'h5A), "R2 clean");
    run_case(enc(7'h7F) ^ 15'h0001, "R3 parity bit 0");
    run_case(enc(7'h33) ^ 15'h4000, "R3 msb");
    run_case(enc(7'h2C) ^ 15'h4001, "R4 wrap pair");
    run_case(enc(7'h11) ^ 15'h4080, "R4 bits 14 and 7");
    run_case(enc(7'h66) ^ 15'h0300, "R4 bits 9 and 8");
    run_case(enc(7'h0F) ^ 15'h0421, "R5 three spread");

    // abort mid-word, then a clean decode
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      run_en = 1'b1;
      serial_in = 1'b1;
    end
    @(negedge clk);
    run_en = 1'b0;
    #1;
    chk(busy == 1'b0, "R7 abort busy", int'(busy), 0);
    @(negedge clk);
    run_case(enc(7'h4B) ^ 15'h0100, "R7 after abort");

    // random words with 0..4 errors
    for (int t = 0; t < 300; t++) begin
      logic [6:0] m = 7'($urandom_range(0, 127));
      int nerr = $urandom_range(0, 4);
      logic [14:0] e = '0;
      while ($countones(e) < nerr) e[$urandom_range(0, 14)] = 1'b1;
      run_case(enc(m) ^ e, "random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule